// File: doc/BRIEF.md
# Integer Status Flag Unit

This unit sits beside a 64-bit integer ALU. It watches the ALU's operands and result, and keeps the fixed-point status flags up to date. The flags are carry, 32-bit carry, overflow, 32-bit overflow and sticky summary overflow. It also produces the 4-bit condition field 0 for record-form operations. The ALU itself is outside this block.

For each operation, the issuing pipeline presents the following, together with a one-cycle valid strobe:

- operand A, and a flag that asks for A to be complemented;
- an optional register operand B and an optional immediate;
- the result;
- an add-class flag;
- per-operation enables for carry, overflow and record;
- a 2-bit mask marking carries that the operation has already written itself;
- an optional divide-overflow value, supplied when the result comes from a divide.

All updates commit on the clock edge where the strobe is high.

The carry flags are inferred by comparing the inputs with the result as unsigned numbers. Add-class operations are the exception: their 32-bit carry is recovered from bit 32 of A, B and the result. Overflow compares signs. The summary bit only ever accumulates.

Top module: `int_flag_unit`

## Requirements
- R1: After reset, the flag output and the condition output are all zero. The flag output bit positions are: [4] summary overflow, [3] overflow, [2] 32-bit overflow, [1] carry, [0] 32-bit carry.
- R2: While the valid strobe is low, neither output changes, whatever the other inputs do.
- R3: When invert-A is high, A is complemented before any flag is computed. The second input is the immediate when imm_valid is high. Otherwise it is B when b_present is high. Otherwise there is no second input.
- R4: With carry enabled and mask bit 0 clear, carry becomes 1 exactly when A or the second input is unsigned-greater than the 64-bit result. Otherwise carry keeps its value.
- R5: For an add-class operation, the 32-bit carry is the XOR of bit 32 of the result, bit 32 of A and bit 32 of the second input. The second input's bit counts as 0 when there is no second input.
- R6: For other operations, the 32-bit carry is 1 when the low 32 bits of A or of the second input are unsigned-greater than the low 32 bits of the result. Either kind of 32-bit carry is written only when carry is enabled and mask bit 1 is clear.
- R7: With overflow enabled and two inputs, overflow is 1 when both inputs share a sign bit (bit 63) and the result's sign bit differs. The 32-bit overflow applies the same test to bit 31.
- R8: When a divide-overflow value is supplied and overflow is enabled, both overflow bits take that value, even with a single input.
- R9: Summary overflow becomes its old value OR the new overflow. It is never cleared except by reset.
- R10: With overflow enabled, a single input and no divide-overflow value, overflow, 32-bit overflow and summary overflow are left unchanged.
- R11: With record enabled, the condition output becomes {negative, positive, zero, summary}. Bits [3:1] compare the signed 64-bit result with zero. Bit [0] is the summary overflow after this operation's update. Without record enabled, the condition output holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Commit strobe for one operation |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Register second operand |
| b_present | input | 1 | opnd_b is an input of this operation |
| imm_val | input | 64 | Immediate operand |
| imm_valid | input | 1 | Immediate replaces the second operand |
| invert_a | input | 1 | Complement opnd_a before flag logic |
| add_class | input | 1 | Operation is an add (XOR-form 32-bit carry) |
| result | input | 64 | ALU result |
| carry_en | input | 1 | Carry flags may be written |
| ovf_en | input | 1 | Overflow flags may be written |
| rec_en | input | 1 | Condition field 0 is written |
| done_mask | input | 2 | [0] carry already written, [1] 32-bit carry already written |
| div_ovf_present | input | 1 | div_ovf_val overrides the sign rule |
| div_ovf_val | input | 1 | Overflow value from a divide |
| flags_out | output | 5 | Status flags (layout in R1) |
| cr0_out | output | 4 | Condition field 0 |

## Verification
Some properties are checked on every cycle:

- The summary bit never falls.
- Nothing moves without the strobe.
- Carry and the condition field hold whenever their enable or mask forbids a write.
- Overflow holds for a single input with no divide value.
- The condition field's sign bits are never more than one-hot.
- A recorded condition field carries the same summary bit as the flags.

Only the bench's scenarios can show that the computed values are correct. These include:

- unsigned carry detection;
- the XOR-form 32-bit carry on an add that wraps;
- the low-half comparison on other operations;
- the effect of inverting A;
- the immediate taking precedence over B;
- the divide-overflow override;
- the negative, zero and positive encodings.

// File: rtl/flag_pkg.sv
package flag_pkg;
    localparam int FLAG_W = 5;

    typedef struct packed {
        logic so;
        logic ov;
        logic ov32;
        logic ca;
        logic ca32;
    } xflags_t;
endpackage

// File: rtl/carry_eval.sv
module carry_eval #(
    parameter int W = 64
) (
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic         b_used,
    input  logic [W-1:0] res,
    input  logic         add_class,
    output logic         ca,
    output logic         ca32
);
    localparam int H = W / 2;

    logic full_a_gt, full_b_gt, half_a_gt, half_b_gt, xor_carry;

    always_comb begin
        full_a_gt = in_a > res;
        full_b_gt = b_used && (in_b > res);
        half_a_gt = in_a[H-1:0] > res[H-1:0];
        half_b_gt = b_used && (in_b[H-1:0] > res[H-1:0]);
        xor_carry = res[H] ^ in_a[H] ^ (b_used & in_b[H]);
        ca        = full_a_gt | full_b_gt;
        ca32      = add_class ? xor_carry : (half_a_gt | half_b_gt);
    end
endmodule

// File: rtl/ovf_eval.sv
module ovf_eval #(
    parameter int W = 64
) (
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic         b_used,
    input  logic [W-1:0] res,
    input  logic         div_present,
    input  logic         div_val,
    output logic         ov_write,
    output logic         ov,
    output logic         ov32
);
    localparam int H = W / 2;

    logic sign_ov, sign_ov32;

    always_comb begin
        sign_ov   = (in_a[W-1] == in_b[W-1]) && (res[W-1] != in_a[W-1]);
        sign_ov32 = (in_a[H-1] == in_b[H-1]) && (res[H-1] != in_a[H-1]);
        ov_write  = div_present | b_used;
        ov        = div_present ? div_val : sign_ov;
        ov32      = div_present ? div_val : sign_ov32;
    end
endmodule

// File: rtl/cr0_eval.sv
module cr0_eval #(
    parameter int W = 64
) (
    input  logic [W-1:0] res,
    input  logic         so_in,
    output logic [3:0]   cr0
);
    logic neg, zer;

    always_comb begin
        neg = res[W-1];
        zer = (res == '0);
        cr0 = {neg, ~neg & ~zer, zer, so_in};
    end
endmodule

// File: rtl/int_flag_unit.sv
module int_flag_unit
    import flag_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              b_present,
    input  logic [DATA_W-1:0] imm_val,
    input  logic              imm_valid,
    input  logic              invert_a,
    input  logic              add_class,
    input  logic [DATA_W-1:0] result,
    input  logic              carry_en,
    input  logic              ovf_en,
    input  logic              rec_en,
    input  logic [1:0]        done_mask,
    input  logic              div_ovf_present,
    input  logic              div_ovf_val,
    output logic [FLAG_W-1:0] flags_out,
    output logic [3:0]        cr0_out
);
    xflags_t           flags_q, flags_d;
    logic [3:0]        cr0_q, cr0_d, cr0_calc;
    logic [DATA_W-1:0] a_eff, b_eff;
    logic              b_used;
    logic              ca_c, ca32_c, ov_w, ov_c, ov32_c;

    // Operand preparation
    always_comb begin
        a_eff  = invert_a ? ~opnd_a : opnd_a;
        b_eff  = imm_valid ? imm_val : opnd_b;
        b_used = imm_valid | b_present;
    end

    carry_eval #(.W(DATA_W)) u_carry (
        .in_a(a_eff), .in_b(b_eff), .b_used(b_used), .res(result),
        .add_class(add_class), .ca(ca_c), .ca32(ca32_c)
    );

    ovf_eval #(.W(DATA_W)) u_ovf (
        .in_a(a_eff), .in_b(b_eff), .b_used(b_used), .res(result),
        .div_present(div_ovf_present), .div_val(div_ovf_val),
        .ov_write(ov_w), .ov(ov_c), .ov32(ov32_c)
    );

    // Next flag state
    always_comb begin
        flags_d = flags_q;
        if (op_valid) begin
            if (carry_en && !done_mask[0]) flags_d.ca   = ca_c;
            if (carry_en && !done_mask[1]) flags_d.ca32 = ca32_c;
            if (ovf_en && ov_w) begin
                flags_d.ov   = ov_c;
                flags_d.ov32 = ov32_c;
                flags_d.so   = flags_q.so | ov_c;
            end
        end
    end

    cr0_eval #(.W(DATA_W)) u_cr0 (
        .res(result), .so_in(flags_d.so), .cr0(cr0_calc)
    );

    always_comb begin
        cr0_d = (op_valid && rec_en) ? cr0_calc : cr0_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            cr0_q   <= '0;
        end else begin
            flags_q <= flags_d;
            cr0_q   <= cr0_d;
        end
    end

    assign flags_out = flags_q;
    assign cr0_out   = cr0_q;

    // Checks beside the state they guard
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(flags_out) && $stable(cr0_out))); // R2
    AST_CA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && carry_en && !done_mask[0]) |=> $stable(flags_out[1])); // R4
    AST_CA32_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && carry_en && !done_mask[1]) |=> $stable(flags_out[0])); // R6
    AST_OV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !b_present && !imm_valid && !div_ovf_present)
        |=> $stable(flags_out[4:2])); // R10
    AST_SO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flags_out[4] |=> flags_out[4]); // R9
    AST_CR0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && rec_en) |=> $stable(cr0_out)); // R11
    AST_CR0_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cr0_out[3:1])); // R11
    AST_CR0_SO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && rec_en) |=> (cr0_out[0] == flags_out[4])); // R11
endmodule

// File: tb/test_int_flag_unit.sv
`timescale 1ns/1ps
module test_int_flag_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid, b_present, imm_valid, invert_a, add_class;
    logic        carry_en, ovf_en, rec_en, div_ovf_present, div_ovf_val;
    logic [63:0] opnd_a, opnd_b, imm_val, result;
    logic [1:0]  done_mask;
    logic [4:0]  flags_out;
    logic [3:0]  cr0_out;

    int checks = 0;
    int errors = 0;

    localparam logic [63:0] ALL1 = 64'hFFFF_FFFF_FFFF_FFFF;

    always #10 clk = ~clk;

    int_flag_unit i_int_flag_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .b_present(b_present),
        .imm_val(imm_val), .imm_valid(imm_valid), .invert_a(invert_a),
        .add_class(add_class), .result(result), .carry_en(carry_en),
        .ovf_en(ovf_en), .rec_en(rec_en), .done_mask(done_mask),
        .div_ovf_present(div_ovf_present), .div_ovf_val(div_ovf_val),
        .flags_out(flags_out), .cr0_out(cr0_out)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_in();
        op_valid = 0; b_present = 0; imm_valid = 0; invert_a = 0; add_class = 0;
        carry_en = 0; ovf_en = 0; rec_en = 0; div_ovf_present = 0; div_ovf_val = 0;
        opnd_a = '0; opnd_b = '0; imm_val = '0; result = '0; done_mask = 2'b00;
    endtask

    // Pulse the strobe for one cycle; outputs are read at the following falling edge
    task automatic commit();
        @(negedge clk) op_valid = 1;
        @(negedge clk) op_valid = 0;
    endtask

    task automatic t_reset();
        clear_in();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 flags", {3'b0, flags_out}, 8'h00);
        chk("R1 cr0", {4'b0, cr0_out}, 8'h0);
    endtask

    task automatic t_carry_add();
        clear_in(); carry_en = 1; add_class = 1; b_present = 1;
        opnd_a = 64'd5; opnd_b = 64'd3; result = 64'd8;
        commit();
        chk("R4 no carry", {7'b0, flags_out[1]}, 8'd0);
        chk("R5 add ca32 clear", {7'b0, flags_out[0]}, 8'd0);
        opnd_a = ALL1; opnd_b = 64'd2; result = 64'd1;
        commit();
        chk("R4 wrap carry", {7'b0, flags_out[1]}, 8'd1);
        chk("R5 xor ca32", {7'b0, flags_out[0]}, 8'd1);
    endtask

    task automatic t_carry_other();
        clear_in(); carry_en = 1; b_present = 1;
        opnd_a = 64'h2_0000_0000; opnd_b = 64'd0; result = 64'h1_0000_0000;
        commit();
        chk("R4 other ca", {7'b0, flags_out[1]}, 8'd1);
        chk("R6 low half no carry", {7'b0, flags_out[0]}, 8'd0);
        opnd_a = 64'h0; opnd_b = 64'h0000_0000_0000_0009; result = 64'h0000_0001_0000_0004;
        commit();
        chk("R4 other no ca", {7'b0, flags_out[1]}, 8'd0);
        chk("R6 low half carry", {7'b0, flags_out[0]}, 8'd1);
    endtask

    task automatic t_mask();
        clear_in(); carry_en = 1; b_present = 1; done_mask = 2'b11;
        opnd_a = ALL1; opnd_b = ALL1; result = 64'd0;
        commit();
        chk("R4 mask holds ca", {7'b0, flags_out[1]}, 8'd0);
        chk("R6 mask holds ca32", {7'b0, flags_out[0]}, 8'd1);
        done_mask = 2'b01; opnd_a = 64'd0; opnd_b = 64'd0; result = 64'd5;
        commit();
        chk("R6 ca32 written under bit0 mask", {7'b0, flags_out[0]}, 8'd0);
        carry_en = 0; done_mask = 2'b00; opnd_a = ALL1; result = 64'd0;
        commit();
        chk("R4 disabled holds", {6'b0, flags_out[1:0]}, 8'd0);
    endtask

    task automatic t_invert();
        clear_in(); carry_en = 1; invert_a = 1;
        opnd_a = 64'd0; result = 64'd0;
        commit();
        chk("R3 inverted A carry", {6'b0, flags_out[1:0]}, 8'h3);
    endtask

    task automatic t_overflow();
        clear_in(); ovf_en = 1; b_present = 1; add_class = 1;
        opnd_a = 64'h7FFF_FFFF_FFFF_FFFF; opnd_b = 64'd1; result = 64'h8000_0000_0000_0000;
        commit();
        chk("R7 ov set ov32 clear", {5'b0, flags_out[4:2]}, 8'b111 & 8'b110);
        chk("R9 so set", {7'b0, flags_out[4]}, 8'd1);
        opnd_a = 64'h7FFF_FFFF; opnd_b = 64'd1; result = 64'h8000_0000;
        commit();
        chk("R7 ov32 only", {6'b0, flags_out[3:2]}, 8'b01);
        opnd_a = 64'd1; opnd_b = 64'd1; result = 64'd2;
        commit();
        chk("R9 so sticky", {5'b0, flags_out[4:2]}, 8'b100);
    endtask

    task automatic t_imm();
        clear_in(); rst_n = 0; @(negedge clk); rst_n = 1;
        ovf_en = 1; b_present = 1; imm_valid = 1;
        opnd_a = 64'h7FFF_FFFF_FFFF_FFFF; opnd_b = ALL1; imm_val = 64'd1;
        result = 64'h8000_0000_0000_0000;
        commit();
        chk("R3 imm wins over B", {7'b0, flags_out[3]}, 8'd1);
    endtask

    task automatic t_div();
        clear_in(); rst_n = 0; @(negedge clk); rst_n = 1;
        ovf_en = 1; div_ovf_present = 1; div_ovf_val = 1;
        commit();
        chk("R8 div ovf one", {5'b0, flags_out[4:2]}, 8'b111);
        div_ovf_val = 0;
        commit();
        chk("R8 div ovf zero", {5'b0, flags_out[4:2]}, 8'b100);
        div_ovf_present = 0; opnd_a = 64'h7FFF_FFFF_FFFF_FFFF; result = 64'h8000_0000_0000_0000;
        div_ovf_present = 1; div_ovf_val = 1; commit();
        div_ovf_present = 0;
        commit();
        chk("R10 single input holds ov", {5'b0, flags_out[4:2]}, 8'b111);
    endtask

    task automatic t_cr0();
        clear_in(); rst_n = 0; @(negedge clk); rst_n = 1;
        rec_en = 1; result = 64'h8000_0000_0000_0001;
        commit();
        chk("R11 negative", {4'b0, cr0_out}, 8'b1000);
        result = 64'd0;
        commit();
        chk("R11 zero", {4'b0, cr0_out}, 8'b0010);
        ovf_en = 1; div_ovf_present = 1; div_ovf_val = 1; result = 64'd42;
        commit();
        chk("R11 positive with new so", {4'b0, cr0_out}, 8'b0101);
        clear_in(); result = ALL1;
        commit();
        chk("R11 no record holds", {4'b0, cr0_out}, 8'b0101);
    endtask

    task automatic t_idle();
        logic [4:0] f0;
        logic [3:0] c0;
        clear_in(); f0 = flags_out; c0 = cr0_out;
        carry_en = 1; ovf_en = 1; rec_en = 1; b_present = 1; div_ovf_present = 1;
        opnd_a = ALL1; opnd_b = ALL1; result = 64'd0;
        repeat (3) @(negedge clk);
        chk("R2 flags idle", {3'b0, flags_out}, {3'b0, f0});
        chk("R2 cr0 idle", {4'b0, cr0_out}, {4'b0, c0});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_carry_add();
        t_carry_other();
        t_mask();
        t_invert();
        t_overflow();
        t_imm();
        t_div();
        t_cr0();
        t_idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule